// File: doc/BRIEF.md
# Programmable DMA Channel Engine

A single DMA channel that copies a programmed number of bytes from a source address to a destination address through one shared request/acknowledge memory port. Software fills in a set of registers and then sets the loading bit of the control register to start the copy. The loading bit reads as set for as long as the copy runs. The engine clears it by itself when the last byte has been written. Software can halt the channel at any point by writing the control register with the loading bit at zero. The read side and the write side are configured independently. Each side has its own beat width, burst length, fixed-or-linear addressing and peripheral request selection. A dedicated mode adds pacing per side: after a block of beats, that side rests for a number of wait cycles. The engine emits a one-cycle half-transfer pulse and a one-cycle end-of-transfer pulse.

Read beats go into a small byte buffer, and write beats take bytes out of it. Because of this, a 32-bit source can feed an 8-bit destination, and the reverse also works. The final beat on each side is shortened to the bytes that remain. The controller is a four-state machine:

- `ST_IDLE`: the channel is stopped. A start write moves it to `ST_PICK`.
- `ST_PICK`: the decision state.
  - It returns to `ST_IDLE` when nothing remains to be written (finish) or when an abort write arrives.
  - Otherwise it goes to `ST_WRITE` when the buffer holds enough bytes and the destination side is allowed to go.
  - Otherwise it goes to `ST_READ` when the buffer has room and the source side is allowed to go.
  - Otherwise it stays in `ST_PICK`.
- `ST_READ` and `ST_WRITE`: these hold the memory request. They return to `ST_PICK` on acknowledge, or to `ST_IDLE` on an abort write.

Top module: `dma_chan_engine`

## Requirements
- R1: Register addresses are: 0 control, 1 source address, 2 destination address, 3 byte count, 4 dedicated parameters. Control bit 31 is the loading bit, and writing it as 1 while the channel is stopped starts a transfer. The loading bit reads 1 while the transfer runs and reads 0 after reset. `mem_req` is only asserted while loading reads 1.
- R2: When the last byte has been written, the engine clears the loading bit. It raises `end_pulse` for exactly one cycle, and that is the first cycle in which loading reads 0.
- R3: Writing control with bit 31 at 0 during a transfer halts the channel. From the next cycle `mem_req` stays low, loading reads 0, and no `end_pulse` is produced.
- R4: While loading reads 1, writes to address 1, address 2, address 3 and address 4 are ignored. A control write with bit 31 at 1 is also ignored entirely: the control readback is unchanged.
- R5: Each side's width code sits in bits [1:0] (source) or [9:8] (destination): 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. `mem_len` gives the beat's byte count minus one. Data travels in the low lanes of the data bus, little-endian. Destination byte k equals source stream byte k for any combination of widths, and the last beat carries only the remaining bytes.
- R6: The fixed-address bit sits in bit 4 (source) or bit 12 (destination). When it is set, that side's address stays constant across beats: source stream byte k is read from src + (k mod source width), and is written to dst + (k mod destination width).
- R7: The request-select field sits in bits [7:5] (source) or [15:13] (destination). Value 0 means the side is not paced. Value n selects `req_lines[n-1]`: a burst on that side starts only in a cycle where that line is high.
- R8: The burst code sits in bits [3:2] (source) or [11:10] (destination): 0 means 1 beat, 1 means 4 beats, 2 means 8 beats. Once a burst has started, its remaining beats proceed without any further request.
- R9: Control bit 16 enables dedicated mode. The parameter register holds, each as its value minus one: source block beats in [7:0], source wait cycles in [15:8], destination block beats in [23:16], and destination wait cycles in [31:24]. After a side completes a block, that side issues no request for at least the programmed number of wait cycles.
- R10: `half_pulse` is raised for exactly one cycle per nonzero transfer, right after the write at which the number of unwritten bytes first becomes at most floor(count/2).
- R11: A start with byte count 0 makes no memory access and ends with a single `end_pulse`, without any `half_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback (combinational) |
| req_lines | input | REQ_LINES | Peripheral request lines |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_len | output | 2 | Beat byte count minus one |
| mem_wdata | output | 32 | Write data, low lanes first |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Beat acknowledge |
| half_pulse | output | 1 | Half-transfer pulse |
| end_pulse | output | 1 | End-of-transfer pulse |

## Verification
A register write takes effect at the clock edge that follows its strobe, and the loading readback is combinational. The bench therefore drives a write on one falling edge and reads the result back on a later falling edge. A beat completes at the edge where the acknowledge is sampled. The bench's memory model commits write data at that same edge, so the memory image is compared only after `end_pulse`. `end_pulse` arrives one `ST_PICK` cycle after the final acknowledge, and the bench waits for it rather than counting beats. Burst lengths, request stalls and wait gaps are measured by counting falling-edge samples between write acknowledges. For a gap, that means counting the samples in which no write is held. The bench therefore checks lower bounds and exact beat counts rather than absolute cycle numbers, and these do not depend on acknowledge latency.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_READ,
        ST_WRITE
    } dce_state_e;

    // one side of the control word, 8 bits
    typedef struct packed {
        logic [2:0] sel;
        logic       fixed;
        logic [1:0] burst;
        logic [1:0] width;
    } dce_side_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        unique case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/dce_pacer.sv
module dce_pacer
    import dce_pkg::*;
#(
    parameter int REQ_LINES = 7,
    parameter int CFG_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [2:0]           sel,
    input  logic [1:0]           burst,
    input  logic                 dedicated,
    input  logic [CFG_W-1:0]     blk_m1,
    input  logic [CFG_W-1:0]     wait_m1,
    input  logic [REQ_LINES-1:0] req_lines,
    input  logic                 beat_done,
    output logic                 side_ok
);

    logic [3:0]     burst_cnt;
    logic [CFG_W-1:0] blk_cnt;
    logic [CFG_W:0] wait_cnt;
    logic           req_hit;

    always_comb begin
        req_hit = (sel == 3'd0);
        for (int i = 0; i < REQ_LINES; i++) begin
            if (sel == 3'(i + 1)) req_hit = req_lines[i];
        end
    end

    assign side_ok = (wait_cnt == '0) && ((burst_cnt != 4'd0) || req_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_cnt <= '0;
            blk_cnt   <= '0;
            wait_cnt  <= '0;
        end else if (restart) begin
            burst_cnt <= '0;
            blk_cnt   <= '0;
            wait_cnt  <= '0;
        end else begin
            if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
            if (beat_done) begin
                burst_cnt <= (burst_cnt == burst_beats(burst) - 4'd1) ? 4'd0 : burst_cnt + 4'd1;
                if (dedicated) begin
                    if (blk_cnt == blk_m1) begin
                        blk_cnt  <= '0;
                        wait_cnt <= {1'b0, wait_m1} + {{CFG_W{1'b0}}, 1'b1};
                    end else begin
                        blk_cnt <= blk_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // a beat never completes while its side is resting
    assert_no_beat_in_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> (wait_cnt == '0));

endmodule

// File: rtl/dce_packer.sv
module dce_packer #(
    parameter int DEPTH = 8,
    parameter int LANE  = 4,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push,
    input  logic [2:0]          push_n,
    input  logic [8*LANE-1:0]   push_data,
    input  logic                pop,
    input  logic [2:0]          pop_n,
    output logic [FILL_W-1:0]   fill,
    output logic [8*LANE-1:0]   head
);

    logic [7:0]        bytes_q [DEPTH];
    logic [7:0]        bytes_d [DEPTH];
    logic [FILL_W-1:0] fill_d;

    always_comb begin
        bytes_d = bytes_q;
        fill_d  = fill;
        if (flush) begin
            fill_d = '0;
        end else if (push) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j >= int'(fill) && j < int'(fill) + int'(push_n))
                    bytes_d[j] = push_data[8*(j - int'(fill)) +: 8];
            end
            fill_d = fill + FILL_W'(push_n);
        end else if (pop) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j + int'(pop_n) < DEPTH) bytes_d[j] = bytes_q[j + int'(pop_n)];
                else                         bytes_d[j] = '0;
            end
            fill_d = fill - FILL_W'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill    <= '0;
            bytes_q <= '{default: '0};
        end else begin
            fill    <= fill_d;
            bytes_q <= bytes_d;
        end
    end

    for (genvar l = 0; l < LANE; l++) begin : g_head
        assign head[8*l +: 8] = bytes_q[l];
    end

    assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(fill) + int'(push_n) <= DEPTH));
    assert_pop_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ({1'b0, pop_n} <= 4'(fill)));
    assert_push_pop_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dce_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int REQ_LINES = 7,
    parameter int BUF_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [REQ_LINES-1:0] req_lines,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [1:0]           mem_len,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ack,
    output logic                 half_pulse,
    output logic                 end_pulse
);

    localparam int LANE   = 4;
    localparam int CFG_W  = 8;
    localparam int FILL_W = $clog2(BUF_BYTES + 1);

    dce_state_e        state, state_d;
    logic [30:0]       ctrl_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q, rd_left, wr_left;
    logic [31:0]       param_q;
    logic              half_done;

    dce_side_t         src_cfg, dst_cfg;
    logic              busy, wr_ctrl, start, abort, fin;
    logic [2:0]        sw, dw, rd_nb, wr_nb;
    logic              want_rd, want_wr, src_ok, dst_ok;
    logic              rd_beat, wr_beat, half_hit;
    logic [FILL_W-1:0] fill;
    logic [31:0]       head;

    assign src_cfg = dce_side_t'(ctrl_q[7:0]);
    assign dst_cfg = dce_side_t'(ctrl_q[15:8]);
    assign busy    = (state != ST_IDLE);
    assign wr_ctrl = reg_we && (reg_addr == 3'd0);
    assign start   = wr_ctrl && reg_wdata[31] && !busy;
    assign abort   = wr_ctrl && !reg_wdata[31] && busy;

    assign sw    = width_bytes(src_cfg.width);
    assign dw    = width_bytes(dst_cfg.width);
    assign rd_nb = (rd_left < CNT_W'(sw)) ? rd_left[2:0] : sw;
    assign wr_nb = (wr_left < CNT_W'(dw)) ? wr_left[2:0] : dw;

    assign want_wr = (wr_left != '0) && (int'(fill) >= int'(wr_nb));
    assign want_rd = (rd_left != '0) && (int'(fill) + int'(rd_nb) <= BUF_BYTES);

    assign rd_beat  = (state == ST_READ)  && mem_ack && !abort;
    assign wr_beat  = (state == ST_WRITE) && mem_ack && !abort;
    assign fin      = (state == ST_PICK) && !abort && (wr_left == '0);
    assign half_hit = !half_done && ((wr_left - CNT_W'(wr_nb)) <= (cnt_q >> 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (start) state_d = ST_PICK;
            ST_PICK: begin
                if (abort || wr_left == '0)  state_d = ST_IDLE;
                else if (want_wr && dst_ok)  state_d = ST_WRITE;
                else if (want_rd && src_ok)  state_d = ST_READ;
            end
            ST_READ, ST_WRITE: begin
                if (abort)        state_d = ST_IDLE;
                else if (mem_ack) state_d = ST_PICK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registers and transfer progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; src_q <= '0; dst_q <= '0; cnt_q <= '0; param_q <= '0;
            rd_left <= '0; wr_left <= '0; half_done <= 1'b0;
        end else begin
            if (reg_we && !busy) begin
                unique case (reg_addr)
                    3'd1:    src_q   <= reg_wdata[ADDR_W-1:0];
                    3'd2:    dst_q   <= reg_wdata[ADDR_W-1:0];
                    3'd3:    cnt_q   <= reg_wdata[CNT_W-1:0];
                    3'd4:    param_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (wr_ctrl && !(busy && reg_wdata[31])) ctrl_q <= reg_wdata[30:0];
            if (start) begin
                rd_left   <= cnt_q;
                wr_left   <= cnt_q;
                half_done <= 1'b0;
            end
            if (rd_beat) begin
                rd_left <= rd_left - CNT_W'(rd_nb);
                if (!src_cfg.fixed) src_q <= src_q + ADDR_W'(rd_nb);
            end
            if (wr_beat) begin
                wr_left <= wr_left - CNT_W'(wr_nb);
                if (!dst_cfg.fixed) dst_q <= dst_q + ADDR_W'(wr_nb);
                if (half_hit) half_done <= 1'b1;
            end
        end
    end

    // event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_pulse <= 1'b0;
            end_pulse  <= 1'b0;
        end else begin
            half_pulse <= wr_beat && half_hit;
            end_pulse  <= fin;
        end
    end

    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = (state == ST_WRITE) ? dst_q : src_q;
    assign mem_len   = 2'((state == ST_WRITE) ? wr_nb - 3'd1 : rd_nb - 3'd1);
    assign mem_wdata = head;

    always_comb begin
        unique case (reg_addr)
            3'd0:    reg_rdata = {busy, ctrl_q};
            3'd1:    reg_rdata = 32'(src_q);
            3'd2:    reg_rdata = 32'(dst_q);
            3'd3:    reg_rdata = 32'(cnt_q);
            3'd4:    reg_rdata = param_q;
            default: reg_rdata = '0;
        endcase
    end

    dce_pacer #(.REQ_LINES(REQ_LINES), .CFG_W(CFG_W)) u_src_pace (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .sel(src_cfg.sel), .burst(src_cfg.burst), .dedicated(ctrl_q[16]),
        .blk_m1(param_q[7:0]), .wait_m1(param_q[15:8]),
        .req_lines(req_lines), .beat_done(rd_beat), .side_ok(src_ok)
    );

    dce_pacer #(.REQ_LINES(REQ_LINES), .CFG_W(CFG_W)) u_dst_pace (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .sel(dst_cfg.sel), .burst(dst_cfg.burst), .dedicated(ctrl_q[16]),
        .blk_m1(param_q[23:16]), .wait_m1(param_q[31:24]),
        .req_lines(req_lines), .beat_done(wr_beat), .side_ok(dst_ok)
    );

    dce_packer #(.DEPTH(BUF_BYTES), .LANE(LANE)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(start),
        .push(rd_beat), .push_n(rd_nb), .push_data(mem_rdata),
        .pop(wr_beat), .pop_n(wr_nb),
        .fill(fill), .head(head)
    );

    assert_start_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[31] && state == ST_IDLE) |=> (state != ST_IDLE));
    assert_end_after_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> (state == ST_IDLE) && ($past(state) == ST_PICK));
    assert_abort_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && !reg_wdata[31] && state != ST_IDLE) |=> (!mem_req && !end_pulse));
    assert_count_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3 && state != ST_IDLE) |=> $stable(cnt_q));
    assert_fixed_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && mem_ack && src_cfg.fixed) |=> $stable(src_q));
    assert_paced_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) == ST_PICK) |-> $past(src_ok));

endmodule

// File: tb/dma_chan_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  req_lines = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_len;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        half_pulse, end_pulse;

    always #2 clk = ~clk;

    dma_chan_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_lines(req_lines),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .half_pulse(half_pulse), .end_pulse(end_pulse)
    );

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0;
    int end_seen, half_seen, wr_beats, req_samples, idle_ctr, min_gap;
    bit have_prev, fast;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] side(input int w, input int b, input int f, input int s);
        return 8'((s << 5) | (f << 4) | (b << 2) | w);
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit go, input bit ded, input logic [7:0] s, input logic [7:0] d);
        return {go, 14'd0, ded, d, s};
    endfunction

    function automatic int wbytes(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    endtask

    // reference model of the byte stream
    task automatic build_exp(input int sw, input bit sf, input int dw, input bit df,
                             input int src, input int dst, input int cnt);
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] b;
            b = sf ? mem[(src + k % sw) & 255] : mem[(src + k) & 255];
            if (df) exp_mem[(dst + k % dw) & 255] = b;
            else    exp_mem[(dst + k) & 255] = b;
        end
    endtask

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    task automatic clear_counts();
        end_seen = 0; half_seen = 0; wr_beats = 0; req_samples = 0;
        have_prev = 0; min_gap = 9999; idle_ctr = 0;
    endtask

    task automatic wait_end(input int lim);
        for (int i = 0; i < lim && end_seen == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(input string tag, input int sw, input int sb, input bit sf, input int ssel,
                            input int dw, input int db, input bit df, input int dsel,
                            input bit ded, input logic [31:0] prm,
                            input int src, input int dst, input int cnt);
        logic [31:0] v;
        fill_mem();
        build_exp(wbytes(sw), sf, wbytes(dw), df, src, dst, cnt);
        clear_counts();
        wr_reg(3'd1, 32'(src));
        wr_reg(3'd2, 32'(dst));
        wr_reg(3'd3, 32'(cnt));
        wr_reg(3'd4, prm);
        wr_reg(3'd0, mk_ctrl(1'b1, ded, side(sw, sb, sf, ssel), side(dw, db, df, dsel)));
        wait_end(6000);
        chk({tag, " R2 end pulses"}, 32'(end_seen), 32'd1);
        chk({tag, " R10 half pulses"}, 32'(half_seen), (cnt > 0) ? 32'd1 : 32'd0);
        rd_reg(3'd0, v);
        chk({tag, " R2 loading cleared"}, {31'd0, v[31]}, 32'd0);
        chk({tag, (sf || df) ? " R6 fixed data" : " R5 data"}, 32'(mem_diff()), 32'd0);
    endtask

    initial begin
        logic [31:0] v, ctl;
        void'($urandom(32'd20240611));
        clear_counts();
        fast = 1'b1;

        fork
            forever begin
                @(negedge clk);
                if (half_pulse) half_seen++;
                if (end_pulse)  end_seen++;
                if (mem_req) req_samples++;
                if (!(mem_req && mem_we)) idle_ctr++;
                if (mem_ack) begin
                    mem_ack = 1'b0;
                end else if (mem_req && (fast || ($urandom % 3) == 0)) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        for (int i = 0; i <= int'(mem_len); i++)
                            mem[(int'(mem_addr[7:0]) + i) & 255] = mem_wdata[8*i +: 8];
                        wr_beats++;
                        if (have_prev && idle_ctr < min_gap) min_gap = idle_ctr;
                        have_prev = 1'b1;
                        idle_ctr = 0;
                    end else begin
                        for (int i = 0; i < 4; i++)
                            mem_rdata[8*i +: 8] = mem[(int'(mem_addr[7:0]) + i) & 255];
                    end
                end
            end
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired R2 actual=running expected=finished");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd_reg(3'd0, v);
        chk("R1 ctrl after reset", v, 32'd0);
        chk("R1 no request after reset", {31'd0, mem_req}, 32'd0);
        chk("R2 no end after reset", {31'd0, end_pulse}, 32'd0);

        // zero count
        fill_mem();
        clear_counts();
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd0, mk_ctrl(1'b1, 1'b0, side(2, 0, 0, 0), side(2, 0, 0, 0)));
        wait_end(100);
        chk("R11 end once", 32'(end_seen), 32'd1);
        chk("R11 no memory access", 32'(req_samples), 32'd0);
        chk("R11 no half", 32'(half_seen), 32'd0);

        // stalled destination, locked registers, abort
        fill_mem();
        clear_counts();
        wr_reg(3'd1, 32'd10);
        wr_reg(3'd2, 32'd150);
        wr_reg(3'd3, 32'd8);
        ctl = mk_ctrl(1'b1, 1'b0, side(0, 0, 0, 0), side(0, 0, 0, 1));
        wr_reg(3'd0, ctl);
        repeat (60) @(negedge clk);
        chk("R7 no write without request", 32'(wr_beats), 32'd0);
        rd_reg(3'd0, v);
        chk("R1 loading while running", v, ctl);
        wr_reg(3'd3, 32'd99);
        rd_reg(3'd3, v);
        chk("R4 count locked", v, 32'd8);
        wr_reg(3'd4, 32'h1234_5678);
        rd_reg(3'd4, v);
        chk("R4 param locked", v, 32'd0);
        wr_reg(3'd0, mk_ctrl(1'b1, 1'b1, side(2, 2, 1, 3), side(1, 1, 1, 2)));
        rd_reg(3'd0, v);
        chk("R4 restart refused", v, ctl);
        wr_reg(3'd0, {1'b0, ctl[30:0]});
        req_samples = 0;
        rd_reg(3'd0, v);
        chk("R3 loading dropped", {31'd0, v[31]}, 32'd0);
        req_lines[0] = 1'b1;
        repeat (20) @(negedge clk);
        req_lines[0] = 1'b0;
        chk("R3 no request after halt", 32'(req_samples), 32'd0);
        chk("R3 no end after halt", 32'(end_seen), 32'd0);
        chk("R3 no write after halt", 32'(wr_beats), 32'd0);

        // burst of four on one request pulse
        fill_mem();
        build_exp(1, 0, 1, 0, 20, 140, 8);
        clear_counts();
        wr_reg(3'd1, 32'd20);
        wr_reg(3'd2, 32'd140);
        wr_reg(3'd3, 32'd8);
        wr_reg(3'd0, mk_ctrl(1'b1, 1'b0, side(0, 0, 0, 0), side(0, 1, 0, 1)));
        repeat (60) @(negedge clk);
        req_lines[0] = 1'b1;
        @(negedge clk);
        req_lines[0] = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8 one burst of four", 32'(wr_beats), 32'd4);
        chk("R10 half after four of eight", 32'(half_seen), 32'd1);
        chk("R2 not yet ended", 32'(end_seen), 32'd0);
        req_lines[0] = 1'b1;
        wait_end(500);
        req_lines[0] = 1'b0;
        chk("R8 end once", 32'(end_seen), 32'd1);
        chk("R8 data", 32'(mem_diff()), 32'd0);

        // dedicated wait gap: block of 1 beat, wait field 3 -> at least 4 idle cycles
        run_xfer("ded", 2, 2, 0, 0, 0, 0, 0, 0, 1'b1, {8'd3, 8'd0, 8'd0, 8'd7}, 8, 160, 6);
        chk("R9 wait gap", (min_gap >= 4) ? 32'd1 : 32'd0, 32'd1);

        // source paced by an asserted line 2
        req_lines[1] = 1'b1;
        run_xfer("paced", 2, 1, 0, 2, 0, 0, 0, 0, 1'b0, 32'd0, 4, 130, 13);
        req_lines[1] = 1'b0;

        // fixed-address corner cases
        run_xfer("fixsrc", 1, 0, 1, 0, 2, 1, 0, 0, 1'b0, 32'd0, 40, 170, 11);
        run_xfer("fixdst", 0, 0, 0, 0, 1, 0, 1, 0, 1'b0, 32'd0, 3, 200, 9);
        run_xfer("one", 2, 2, 0, 0, 2, 2, 0, 0, 1'b0, 32'd0, 7, 133, 1);

        // random mix
        fast = 1'b0;
        for (int t = 0; t < 30; t++) begin
            int cnt;
            cnt = 1 + int'($urandom % 40);
            run_xfer("rand", int'($urandom % 3), int'($urandom % 3), 1'($urandom % 2), 0,
                     int'($urandom % 3), int'($urandom % 3), 1'($urandom % 2), 0,
                     1'($urandom % 2),
                     {8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4)},
                     int'($urandom % 80), 128 + int'($urandom % 80), cnt);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule